// File: doc/BRIEF.md
# Narrow-Width Integer ALU with Zero-Extended Results

This block is a single-lane 64-bit integer execution slice for scalar (non-lane) operations. Every operation carries a two-bit size code that picks an operating width of 8, 16, 32 or 64 bits. Only the low part of the destination is meaningful, and every destination bit at or above the chosen width is written as zero. This zero-extension means software can merge partial results with shifts and ORs and never needs to mask first.

Upper-bit clearing is not done with a full row of AND gates on the result. The operands are masked to the chosen width where they leave the register file. Zero-preserving operations (AND, OR, XOR, AND-NOT) then give clean upper bits on their own. Only the operations that can turn zeros into ones get a local correction: NOR, and ADD/SUB, whose carry or borrow can run past the width.

The result is held in one output register with a single cycle of latency. The writeback port and the bypass port both read that same register, so a dependent operation always sees exactly the value that reaches the register file.

Top module: `pzx_alu`

## Requirements
- R1: `in_size` selects the width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. The low width bits of the result equal the operation applied to the low width bits of the operands. `in_op` encodes ADD=0, SUB=1 (a minus b), AND=2, OR=3, XOR=4, NOR=5 and ANDN=6 (a AND NOT b).
- R2: For every operation at a width below 64, all result bits from the width up to bit 63 are zero.
- R3: NOR at a width below 64 produces ones only below the width. For example, NOR of two zero operands at 8 bits gives 64'hFF.
- R4: An ADD whose carry runs out of the selected width drops that carry. For example, 8'hFF + 1 at 8 bits gives 0.
- R5: SUB clears the borrow bits above the width. For example, 0 - 1 at 16 bits gives 64'hFFFF.
- R6: At the 64-bit width no masking is applied. NOR of zeros gives all ones, and ADD wraps modulo 2^64.
- R7: Operand bits at or above the selected width have no effect on the result.
- R8: A result appears one clock after the cycle in which `in_valid` is high, with `out_valid` high. `out_valid` is low one clock after any cycle in which `in_valid` is low.
- R9: `byp_data` is bit-identical to `wb_data` at all times.
- R10: While `in_valid` is low, `wb_data` and `byp_data` keep their previous value.
- R11: A synchronous active-low reset clears `out_valid`, `wb_data` and `byp_data` to zero.
- R12: The reserved operation code 7 produces a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Width code |
| in_a | input | 64 | First operand, as read from the register file |
| in_b | input | 64 | Second operand, as read from the register file |
| out_valid | output | 1 | Result register holds a new result |
| wb_data | output | 64 | Result to the register-file write port |
| byp_data | output | 64 | Result to the bypass network |

## Verification
The bench targets the operations that can produce nonzero bits from zero operands. A design that handled NOR only with operand masking would return ones above the width. A missing adder correction would leak a carry or a whole field of borrow ones into bit 8, 16 or 32. Operands are given garbage above the width, which exposes masking that is missing or tied to the wrong size code. The bench also checks that the 64-bit case is left unmasked, that the output holds while `in_valid` is low, and that bypass and writeback never differ.

// File: rtl/pzx_pkg.sv
// Package: shared widths, operation and size encodings for the narrow-width ALU.
// Assumes a register width of exactly eight lanes so a 2-bit size code covers it.
package pzx_pkg;
    parameter int unsigned XLEN   = 64;
    parameter int unsigned LANE_W = 8;
    localparam int unsigned NUM_LANES = XLEN / LANE_W;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOR  = 3'd5,
        OP_ANDN = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    // True for operations that go through the adder
    function automatic logic op_is_arith(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/pzx_width_mask.sv
// Module: turns a size code into a per-bit keep mask, built lane by lane.
// Assumes each size step doubles the number of enabled lanes, starting at one.
module pzx_width_mask #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN,
    parameter int unsigned LANE_W = pzx_pkg::LANE_W
) (
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] mask_o
);
    localparam int unsigned NUM_LANES = DATA_W / LANE_W;

    logic [NUM_LANES-1:0] lane_en;

    for (genvar i = 0; i < int'(NUM_LANES); i++) begin : g_lane
        // Enable lane i when it lies below the selected width
        always_comb lane_en[i] = (32'(i) < (32'd1 << size_i));
        assign mask_o[i*LANE_W +: LANE_W] = {LANE_W{lane_en[i]}};
    end
endmodule

// File: rtl/pzx_operand_gate.sv
// Module: register-read-side operand masking; clears both operands above the width.
// Assumes the mask comes from pzx_width_mask for the same operation.
module pzx_operand_gate #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    // Gate each operand with the width mask
    always_comb begin
        a_o = a_i & mask_i;
        b_o = b_i & mask_i;
    end

    // R7: once masked, operands carry no bits at or above the width into the units
    p_operand_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (((a_o | b_o) & ~mask_i) == '0));
endmodule

// File: rtl/pzx_logic_unit.sv
// Module: bitwise operations on masked operands. Only NOR needs a correction,
// because it maps zero inputs to one. ANDN stays clean since a is zero above the width.
// Assumes the operands are already masked; the reserved code yields zero.
module pzx_logic_unit #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    import pzx_pkg::*;

    logic [DATA_W-1:0] nor_raw;
    logic              zero_preserving;

    // Raw NOR, before the targeted upper-bit fix
    always_comb nor_raw = ~(a_i | b_i);

    // Identify operations that keep zero operands at zero
    always_comb zero_preserving = (op_i == OP_AND) || (op_i == OP_OR) ||
                                  (op_i == OP_XOR) || (op_i == OP_ANDN);

    // Select the bitwise result; NOR is the only one re-masked
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_ANDN: res_o = a_i & ~b_i;
            OP_NOR:  res_o = nor_raw & mask_i;
            default: res_o = '0;
        endcase
    end

    // R2: masked operands alone keep zero-preserving results clean above the width
    p_zero_preserving_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && zero_preserving && (((a_i | b_i) & ~mask_i) == '0))
            |-> ((res_o & ~mask_i) == '0));
endmodule

// File: rtl/pzx_arith_unit.sv
// Module: add/subtract on masked operands, with carry and borrow cleared above the width.
// Assumes masked operands; SUB is computed as a + ~b + 1.
module pzx_arith_unit #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    import pzx_pkg::*;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;

    // Invert the second operand for subtraction
    always_comb begin
        is_sub = (op_i == OP_SUB);
        b_eff  = is_sub ? ~b_i : b_i;
    end

    // Full-width adder; the carry-in supplies the +1 for subtraction
    always_comb sum = a_i + b_eff + {{(DATA_W-1){1'b0}}, is_sub};

    // Drop any carry or borrow bits that ran past the width
    always_comb res_o = sum & mask_i;
endmodule

// File: rtl/pzx_result_stage.sv
// Module: the single result register. Writeback and bypass both read it,
// so they cannot diverge. Assumes synchronous active-low reset.
module pzx_result_stage #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    // Track whether a new result was captured this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Load the result only for a valid operation, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)       data_o <= '0;
        else if (valid_i) data_o <= data_i;
    end

    // R8: one-cycle latency of the valid flag
    p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    // R10: data holds when nothing is issued
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(data_o));
    // R11: reset leaves the stage empty and cleared
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && (data_o == '0)));
endmodule

// File: rtl/pzx_alu.sv
// Module: top of the narrow-width ALU. It masks the operands at the read side,
// runs the arithmetic and logic units side by side, selects one result and registers it.
// Assumes DATA_W is eight lanes of LANE_W bits.
module pzx_alu #(
    parameter int unsigned DATA_W = pzx_pkg::XLEN,
    parameter int unsigned LANE_W = pzx_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] byp_data
);
    import pzx_pkg::*;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_m, b_m;
    logic [DATA_W-1:0] arith_res, logic_res, next_res;
    logic [DATA_W-1:0] res_q;

    pzx_width_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
        .size_i (in_size),
        .mask_o (mask)
    );

    pzx_operand_gate #(.DATA_W(DATA_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .mask_i  (mask),
        .a_i     (in_a),
        .b_i     (in_b),
        .a_o     (a_m),
        .b_o     (b_m)
    );

    pzx_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_i   (in_op),
        .mask_i (mask),
        .a_i    (a_m),
        .b_i    (b_m),
        .res_o  (arith_res)
    );

    pzx_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .op_i    (in_op),
        .mask_i  (mask),
        .a_i     (a_m),
        .b_i     (b_m),
        .res_o   (logic_res)
    );

    // Pick the unit that owns this operation code
    always_comb next_res = op_is_arith(in_op) ? arith_res : logic_res;

    pzx_result_stage #(.DATA_W(DATA_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .data_i  (next_res),
        .valid_o (out_valid),
        .data_o  (res_q)
    );

    // Both consumers are fed from the single result register
    assign wb_data  = res_q;
    assign byp_data = res_q;

    // R2: a registered result never has bits above the width it was issued with
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((wb_data & ~$past(mask)) == '0));
    // R12: the reserved code registers a zero result
    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_RSVD)) |=> (wb_data == '0));
endmodule

// File: tb/pzx_alu_test.sv
`timescale 1ns/1ps
module pzx_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_a = '0, in_b = '0;
    logic        out_valid;
    logic [63:0] wb_data, byp_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pzx_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .wb_data(wb_data), .byp_data(byp_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  size;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd5, 2'd0, 64'h0, 64'h0, 64'h0000_0000_0000_00FF},                   // R3
        '{3'd5, 2'd2, 64'h0, 64'h0, 64'h0000_0000_FFFF_FFFF},                   // R3
        '{3'd5, 2'd3, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},                   // R6
        '{3'd0, 2'd0, 64'hFF, 64'h1, 64'h0},                                    // R4
        '{3'd0, 2'd1, 64'hFFFF, 64'hFFFF, 64'h0000_0000_0000_FFFE},             // R4
        '{3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1},                   // R6
        '{3'd1, 2'd1, 64'h0, 64'h1, 64'h0000_0000_0000_FFFF},                   // R5
        '{3'd1, 2'd2, 64'h5, 64'h7, 64'h0000_0000_FFFF_FFFE},                   // R5
        '{3'd2, 2'd0, 64'hDEAD_BEEF_CAFE_F00F, 64'hFFFF_FFFF_FFFF_FF0F, 64'h0F}, // R7
        '{3'd3, 2'd1, 64'hAAAA_0000_0000_1200, 64'h5555_0000_0000_0034, 64'h1234}, // R7
        '{3'd4, 2'd2, 64'hFFFF_FFFF_0F0F_0F0F, 64'h1234_5678_FFFF_0000, 64'hF0F0_0F0F}, // R1
        '{3'd6, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0030, 64'hC0}, // R1
        '{3'd7, 2'd3, 64'h1234, 64'h5678, 64'h0},                               // R12
        '{3'd5, 2'd1, 64'hFFFF_FFFF_FFFF_0F0F, 64'h0, 64'h0000_0000_0000_F0F0}  // R3
    };

    // Reference model: operation on raw operands, then cut to the width
    function automatic logic [63:0] ref_model(logic [2:0] op, logic [1:0] sz,
                                              logic [63:0] a, logic [63:0] b);
        logic [63:0] m, r;
        m = (sz == 2'd3) ? '1 : ((64'h1 << (8 << sz)) - 64'h1);
        case (op)
            3'd0: r = a + b;
            3'd1: r = a - b;
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = ~(a | b);
            3'd6: r = a & ~b;
            default: r = '0;
        endcase
        return r & m;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation, then sample one clock later, away from the edge
    task automatic issue(logic [2:0] op, logic [1:0] sz, logic [63:0] a,
                         logic [63:0] b, logic [63:0] exp, string req);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b;
        @(posedge clk); #1;
        check({req, " result"}, wb_data, exp);
        check("R9 bypass", byp_data, wb_data);
        check("R8 valid", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] held;
        // R11: reset state, with an operation presented during reset
        in_valid = 1'b1; in_op = 3'd5; in_size = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R11 out_valid", {63'd0, out_valid}, 64'd0);
        check("R11 wb_data", wb_data, 64'd0);
        check("R11 byp_data", byp_data, 64'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

        // Table walk: directed corner vectors
        for (int i = 0; i < NV; i++) begin
            check("R1 table reference", ref_model(VEC[i].op, VEC[i].size, VEC[i].a, VEC[i].b), VEC[i].exp);
            issue(VEC[i].op, VEC[i].size, VEC[i].a, VEC[i].b, VEC[i].exp, "R2 table");
        end

        // R1 R2 R7: random operands, every size and operation
        for (int k = 0; k < 400; k++) begin
            logic [63:0] ra, rb;
            logic [2:0]  op;
            logic [1:0]  sz;
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
            op = 3'(k % 7); sz = 2'((k / 7) % 4);
            issue(op, sz, ra, rb, ref_model(op, sz, ra, rb), "R1 random");
        end

        // R10: idle cycles hold the last result while inputs change
        issue(3'd5, 2'd0, 64'h0, 64'h0, 64'hFF, "R3 pre-idle");
        held = wb_data;
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd0; in_a = 64'h1111; in_b = 64'h2222; in_size = 2'd3;
        @(posedge clk); #1;
        check("R10 hold", wb_data, held);
        check("R8 valid low", {63'd0, out_valid}, 64'd0);
        check("R9 bypass idle", byp_data, held);

        // R11: reset mid-run clears the register
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 mid reset", wb_data, 64'd0);
        check("R11 mid valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule